// File: doc/BRIEF.md
# Self-Reloading Counter Bank for Switching-Activity Emulation

The block is a bank of small up-counters that share one data word. The word is split into nibbles, and each counter takes its own nibble. A counter loads its nibble, counts up by one on every clock, and reloads from its nibble when it reaches all ones. It does not wrap to zero.

The top bit of each counter is brought out as a registered enable line. That line switches a group of external current sinks. The data word is meant to come from a pseudorandom source. Because the reload value is random, each enable line changes with a period and duty cycle that vary over time. This imitates the data-dependent current draw of real logic. Each counter value is also brought out so that it can be observed.

Top module: `rcb_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every counter value becomes 0 and every enable line becomes 0.
- R2: At the first rising edge after `rst_n` returns high, counter i loads `load_word[4i+3:4i]`.
- R3: A counter that is not in its post-reset load and does not hold 4'hF increases by exactly one at each rising edge.
- R4: A counter that holds 4'hF loads the value its nibble has at the next rising edge, and does not wrap to 0.
- R5: When the value loaded is 4'hF, the counter reloads again at the rising edge that follows.
- R6: Enable line i always equals bit 3 of counter i. The enable comes from a register, so changing `load_word` between clock edges does not change any enable line or counter value.
- R7: The counters are independent. A counter's reload depends only on its own value and its own nibble, even when the other counters count normally at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_word | input | 16 | Reload data; counter i takes bits [4i+3:4i] |
| sink_en | output | 4 | Registered enable per counter (counter MSB) for external current sinks |
| ctr_val | output | 16 | Counter values; counter i is in bits [4i+3:4i] |

## Verification
The assertions assume that `load_word` is stable and known at every rising edge. They also assume that reset is held for at least one edge before counting is judged. The properties that refer to the nibble through `$past` depend on both of these.

The bench changes the data only at falling edges and begins every run with a reset cycle. It steers the nibbles to reach the edge cases: a reload of 4'hF, a reload of 0, and the 7-to-8 crossing that raises an enable. A separate scenario changes the data halfway between edges to show that the outputs stay as they were.

// File: rtl/rcb_pkg.sv
// Package: shared sizing for the self-reloading counter bank.
// Assumes: nibble-wide counters packed side by side in one data word.
package rcb_pkg;
    localparam int unsigned RCB_NUM_CTR = 4;
    localparam int unsigned RCB_CTR_W   = 4;
    localparam int unsigned RCB_DATA_W  = RCB_NUM_CTR * RCB_CTR_W;
endpackage

// File: rtl/rcb_reload_dec.sv
// Module: rcb_reload_dec
// Decides whether a counter takes its reload value at the next edge.
// A reload happens while a post-reset load is pending or when the
// counter holds all ones.
// Assumes: purely combinational; the caller registers the result.
module rcb_reload_dec #(
    parameter int unsigned CTR_W = 4
) (
    input  logic [CTR_W-1:0] cnt,
    input  logic             pend,
    output logic             reload
);
    // Reload condition: pending first load or terminal (all-ones) count.
    always_comb begin
        reload = pend | (&cnt);
    end
endmodule

// File: rtl/rcb_lane.sv
// Module: rcb_lane
// One self-reloading up-counter with a registered MSB enable.
// Assumes: nib is stable at each rising edge; reset is synchronous and active low.
module rcb_lane #(
    parameter int unsigned CTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTR_W-1:0] nib,
    output logic [CTR_W-1:0] cnt_q,
    output logic             msb_q
);
    logic             pend_q;
    logic             reload;
    logic [CTR_W-1:0] cnt_d;

    rcb_reload_dec #(.CTR_W(CTR_W)) u_dec (
        .cnt    (cnt_q),
        .pend   (pend_q),
        .reload (reload)
    );

    // Next count: the input nibble on reload, otherwise one higher.
    always_comb begin
        cnt_d = reload ? nib : cnt_q + 1'b1;
    end

    // Counter state, plus a flag that forces a load after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= 1'b0;
        end
    end

    // Enable register: a separate flop that holds the MSB of the next count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msb_q <= 1'b0;
        end else begin
            msb_q <= cnt_d[CTR_W-1];
        end
    end

    // R1: reset clears the count and arms the first load.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0) && pend_q && !msb_q);

    // R2: the pending load takes the nibble.
    p_first_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> (cnt_q == $past(nib)) && !pend_q);

    // R3: a normal step adds one.
    p_count_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !(&cnt_q)) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R4/R5: the all-ones state reloads instead of wrapping.
    p_reload_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt_q) |=> cnt_q == $past(nib));

    // R6: the enable register tracks the counter MSB.
    p_en_tracks_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        msb_q == cnt_q[CTR_W-1]);

    // R6: the enable rises only from a load or from the midpoint crossing.
    p_en_rise_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msb_q) |-> ($past(pend_q) || ($past(cnt_q) == {1'b0, {(CTR_W-1){1'b1}}})
                          || (&$past(cnt_q))));
endmodule

// File: rtl/rcb_bank.sv
// Module: rcb_bank (top)
// A bank of self-reloading counters. Each counter takes its own nibble
// of load_word and drives one sink enable from its MSB.
// Assumes: load_word comes from a pseudorandom source and is stable at edges.
module rcb_bank
    import rcb_pkg::*;
#(
    parameter int unsigned NUM_CTR = RCB_NUM_CTR,
    parameter int unsigned CTR_W   = RCB_CTR_W,
    localparam int unsigned DATA_W = NUM_CTR * CTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] load_word,
    output logic [NUM_CTR-1:0] sink_en,
    output logic [DATA_W-1:0] ctr_val
);
    // One lane per nibble; lane i owns bits [CTR_W*i +: CTR_W].
    for (genvar gi = 0; gi < NUM_CTR; gi++) begin : g_lane
        rcb_lane #(.CTR_W(CTR_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .nib   (load_word[gi*CTR_W +: CTR_W]),
            .cnt_q (ctr_val[gi*CTR_W +: CTR_W]),
            .msb_q (sink_en[gi])
        );
    end

    // R7: lane 0 reloads from its own nibble even when its neighbour does not reload.
    p_lane_indep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((&ctr_val[CTR_W-1:0]) && !(&ctr_val[2*CTR_W-1:CTR_W]) && !$past(!rst_n)) |=>
        (ctr_val[CTR_W-1:0] == $past(load_word[CTR_W-1:0])) &&
        (ctr_val[2*CTR_W-1:CTR_W] == $past(ctr_val[2*CTR_W-1:CTR_W]) + 1'b1));
endmodule

// File: tb/tb_rcb_bank.sv
module tb_rcb_bank;
    localparam int N = 4;
    localparam int W = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N*W-1:0] load_word = '0;
    logic [N-1:0]  sink_en;
    logic [N*W-1:0] ctr_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [W-1:0] m_cnt [N];
    bit           m_pend;

    rcb_bank dut (
        .clk(clk), .rst_n(rst_n), .load_word(load_word),
        .sink_en(sink_en), .ctr_val(ctr_val)
    );

    always #5 clk = ~clk;

    // Compare every lane's value and enable against the model.
    task automatic compare(string req);
        logic [N*W-1:0] ev;
        logic [N-1:0]   ee;
        for (int i = 0; i < N; i++) begin
            ev[i*W +: W] = m_cnt[i];
            ee[i]        = m_cnt[i][W-1];
        end
        n_chk++;
        if (ctr_val !== ev || sink_en !== ee) begin
            n_bad++;
            $display("FAIL %s: ctr_val=%h sink_en=%b expected ctr_val=%h sink_en=%b",
                     req, ctr_val, sink_en, ev, ee);
        end
    endtask

    // Apply one word for one edge, advance the model, check at the falling edge.
    task automatic step(logic [N*W-1:0] d, string req);
        load_word = d;
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (!rst_n) m_cnt[i] = '0;
            else if (m_pend || m_cnt[i] == 4'hF) m_cnt[i] = d[i*W +: W];
            else m_cnt[i] = m_cnt[i] + 1'b1;
        end
        m_pend = !rst_n;
        @(negedge clk);
        compare(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(16'hFFFF, "R1");
        step(16'h9A5C, "R1");
        rst_n = 1'b1;
    endtask

    // R1/R2: reset clears the bank, then the first edge loads every nibble.
    task automatic t_reset_and_load();
        do_reset();
        step(16'h80F3, "R2");
    endtask

    // R3/R4: count up through the terminal value, then reload a fresh nibble.
    task automatic t_count_and_reload();
        do_reset();
        step(16'hC9D7, "R2");
        for (int k = 0; k < 10; k++) step(16'h1234, "R3");
        step(16'h0000, "R4");
        step(16'h5A5A, "R4");
    endtask

    // R5: a loaded all-ones nibble reloads again on the next edge.
    task automatic t_load_max();
        do_reset();
        step(16'hFFFF, "R5");
        step(16'hFFFF, "R5");
        step(16'h0000, "R5");
        step(16'h0000, "R3");
    endtask

    // R6: data changes between edges leave the registered outputs alone.
    task automatic t_no_comb_path();
        logic [N*W-1:0] v0;
        logic [N-1:0]   e0;
        do_reset();
        step(16'h7777, "R6");
        v0 = ctr_val; e0 = sink_en;
        load_word = 16'hFFFF;
        #2;
        n_chk++;
        if (ctr_val !== v0 || sink_en !== e0) begin
            n_bad++;
            $display("FAIL R6: ctr_val=%h sink_en=%b expected ctr_val=%h sink_en=%b",
                     ctr_val, sink_en, v0, e0);
        end
        step(16'h0000, "R6");
    endtask

    // R7: lanes at different phases reload independently.
    task automatic t_independent();
        do_reset();
        step(16'hE8F0, "R7");
        for (int k = 0; k < 20; k++) step(16'h3C6B ^ (k * 16'h1111), "R7");
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_cnt[i] = '0;
        m_pend = 1'b1;
        t_reset_and_load();
        t_count_and_reload();
        t_load_max();
        t_no_comb_path();
        t_independent();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule